// File: doc/BRIEF.md
# Multicore Interrupt Routing Controller

This block gathers level-sensitive interrupt lines and hands each of up to four CPUs the lowest-numbered interrupt that is waiting for it. A source reaches a CPU only when three things allow it. Its global enable must be on. The CPU's own mask must not hold it off. Its routing mask must name that CPU. Software turns enables and masks on and off by writing a source index to a dedicated address, so no read-modify-write is needed. Each source also has its own routing register.

Two identifiers are reserved. ID 0 carries a per-CPU inter-processor doorbell summary and ID 1 carries a per-CPU message doorbell summary. Both come in as inputs. One designated source, number 5 by default, has a separate line for every CPU. It depends only on that CPU's mask. Each CPU reads an acknowledge word that names the winning ID, and it also gets an interrupt output that is high whenever a winner exists.

Register access is a 32-bit port. Address bit 12 chooses between the shared window (0) and the window of the CPU given by `cpu_sel` (1). Read data comes back registered.

Top module: `mic_top`

## Requirements
- R1: After reset every enable is off, every mask bit of every CPU is set, every routing register reads 1 (CPU 0), every `irq_out` bit is low and every acknowledge read gives 1023.
- R2: A write to shared offset 0x030 turns on the enable of the source whose index is in `wdata`, and a write to shared offset 0x034 turns it off. Index values of NSRC or more change nothing, even where their low bits match a real source.
- R3: A write to per-CPU offset 0x048 masks source `wdata` for the CPU on `cpu_sel`, and a write to 0x04C unmasks it. Other CPUs' masks are unchanged.
- R4: A read of shared offset 0x000 returns NSRC in bits [11:2] and zero in all other bits.
- R5: The routing register of source n is at shared offset 0x100+4n. Its low NCPU bits are stored and read back, with one bit per CPU and bit 0 standing for CPU 0. An ordinary source is delivered only to CPUs whose bit is set.
- R6: A read of per-CPU offset 0x044 returns in bits [9:0] the lowest pending ID for that CPU, or 1023 when none is pending, and returns zero in bits [31:10]. Reading it does not clear anything: a source stays pending until its line drops.
- R7: ID 0 is pending for CPU c when `ipi_sum[c]` is high and c has mask bit 0 clear. ID 1 is pending for CPU c when `msg_sum[c]` is high and c has mask bit 1 clear. Enables and routing have no effect on either ID.
- R8: The per-CPU source (ID 5) is pending for CPU c when `pcpu_lvl[c]` is high and c has mask bit 5 clear. Its enable, its routing and `src_lvl[5]` have no effect on it.
- R9: A read of per-CPU offset 0x010 returns `msg_sum` of the selected CPU in bit 0 and `pcpu_lvl` of that CPU in bit 5. All other bits read zero.
- R10: `irq_out[c]` is high in exactly the cycles in which CPU c's acknowledge value is 1022 or less.
- R11: `rdata` is loaded on the clock edge that samples `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 2 | CPU whose window is accessed |
| addr | input | 13 | Byte address; bit 12 selects the per-CPU window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_lvl | input | 32 | Level lines of the shared sources |
| pcpu_lvl | input | 4 | Per-CPU source line, one per CPU |
| ipi_sum | input | 4 | Inter-processor doorbell summary per CPU |
| msg_sum | input | 4 | Message doorbell summary per CPU |
| irq_out | output | 4 | Interrupt request per CPU |

## Verification
The routing path is tried in several ways. One source is opened stage by stage: enable, then mask, then route. This shows that each gate blocks on its own. Two sources are raised together to show that the lowest ID wins. The winner is then taken away, by a disable and by an out-of-range index that aliases it, which separates a true clear from a truncated index. The doorbell summaries and the per-CPU line are raised on CPUs with different masks. The per-CPU line is also raised alongside a high `src_lvl[5]` whose enable is on, which shows that shared state does not reach that source.

// File: rtl/mic_pkg.sv
package mic_pkg;

    localparam int ADDR_W = 13;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

    localparam logic [11:0] OFS_CTRL    = 12'h000;
    localparam logic [11:0] OFS_EN_ON   = 12'h030;
    localparam logic [11:0] OFS_EN_OFF  = 12'h034;
    localparam logic [11:0] OFS_CAUSE   = 12'h010;
    localparam logic [11:0] OFS_ACK     = 12'h044;
    localparam logic [11:0] OFS_MSK_ON  = 12'h048;
    localparam logic [11:0] OFS_MSK_OFF = 12'h04C;
    localparam logic [9:0]  ROUTE_WORD0 = 10'h040;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_EN_ON,
        ACC_EN_OFF,
        ACC_ROUTE,
        ACC_CAUSE,
        ACC_ACK,
        ACC_MSK_ON,
        ACC_MSK_OFF
    } acc_e;

endpackage

// File: rtl/mic_decode.sv
module mic_decode
    import mic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind,
    output logic [IDX_W-1:0]  ridx
);

    logic        win;
    logic [11:0] off;
    logic [9:0]  rel;
    logic        route_hit;

    assign win       = addr[ADDR_W-1];
    assign off       = addr[11:0];
    assign rel       = off[11:2] - ROUTE_WORD0;
    assign route_hit = !win && (off[11:2] >= ROUTE_WORD0) &&
                       (rel < 10'(NSRC)) && (off[1:0] == 2'b00);
    assign ridx      = rel[IDX_W-1:0];

    always_comb begin
        unique case ({win, off})
            {1'b0, OFS_CTRL}:    kind = ACC_CTRL;
            {1'b0, OFS_EN_ON}:   kind = ACC_EN_ON;
            {1'b0, OFS_EN_OFF}:  kind = ACC_EN_OFF;
            {1'b1, OFS_CAUSE}:   kind = ACC_CAUSE;
            {1'b1, OFS_ACK}:     kind = ACC_ACK;
            {1'b1, OFS_MSK_ON}:  kind = ACC_MSK_ON;
            {1'b1, OFS_MSK_OFF}: kind = ACC_MSK_OFF;
            default:             kind = route_hit ? ACC_ROUTE : ACC_NONE;
        endcase
    end

endmodule

// File: rtl/mic_regs.sv
module mic_regs
    import mic_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NSRC  = 32,
    parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  acc_e                       kind,
    input  logic [CPU_W-1:0]           cpu_sel,
    input  logic [31:0]                wdata,
    input  logic [IDX_W-1:0]           ridx,
    output logic [NSRC-1:0]            en,
    output logic [NCPU-1:0][NSRC-1:0]  msk,
    output logic [NSRC-1:0][NCPU-1:0]  route
);

    logic             idx_ok;
    logic [IDX_W-1:0] idx;

    assign idx_ok = (wdata < 32'(NSRC));
    assign idx    = wdata[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= '0;
            msk <= '1;
            for (int s = 0; s < NSRC; s++) begin
                route[s] <= NCPU'(1);
            end
        end else if (wr_en) begin
            unique case (kind)
                ACC_EN_ON:   if (idx_ok) en[idx] <= 1'b1;
                ACC_EN_OFF:  if (idx_ok) en[idx] <= 1'b0;
                ACC_MSK_ON:  if (idx_ok) msk[cpu_sel][idx] <= 1'b1;
                ACC_MSK_OFF: if (idx_ok) msk[cpu_sel][idx] <= 1'b0;
                ACC_ROUTE:   route[ridx] <= wdata[NCPU-1:0];
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/mic_pick.sv
module mic_pick
    import mic_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSRC = 32,
    parameter int PCPU = 5
) (
    input  logic [NSRC-1:0]            src_lvl,
    input  logic [NCPU-1:0]            pcpu_lvl,
    input  logic [NCPU-1:0]            ipi_sum,
    input  logic [NCPU-1:0]            msg_sum,
    input  logic [NSRC-1:0]            en,
    input  logic [NCPU-1:0][NSRC-1:0]  msk,
    input  logic [NSRC-1:0][NCPU-1:0]  route,
    output logic [NCPU-1:0][ID_W-1:0]  ack_id,
    output logic [NCPU-1:0]            irq
);

    logic [NCPU-1:0][NSRC-1:0] pend;
    logic [NSRC-1:0]           spare;
    logic                      unused_spare;

    for (genvar s = 0; s < NSRC; s++) begin : g_spare
        if (s == 0 || s == 1 || s == PCPU) begin : g_rsv
            assign spare[s] = src_lvl[s] ^ en[s] ^ (^route[s]);
        end else begin : g_ord
            assign spare[s] = 1'b0;
        end
    end
    assign unused_spare = ^spare;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            if (s == 0) begin : g_ipi
                assign pend[c][s] = ipi_sum[c] & ~msk[c][s];
            end else if (s == 1) begin : g_msg
                assign pend[c][s] = msg_sum[c] & ~msk[c][s];
            end else if (s == PCPU) begin : g_pcpu
                assign pend[c][s] = pcpu_lvl[c] & ~msk[c][s];
            end else begin : g_shared
                assign pend[c][s] = src_lvl[s] & en[s] & route[s][c] & ~msk[c][s];
            end
        end

        always_comb begin
            ack_id[c] = ID_NONE;
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (pend[c][i]) ack_id[c] = ID_W'(i);
            end
        end

        assign irq[c] = (ack_id[c] != ID_NONE);
    end

endmodule

// File: rtl/mic_top.sv
module mic_top
    import mic_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NSRC  = 32,
    parameter int PCPU  = 5,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_W-1:0]  cpu_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic [NCPU-1:0]   pcpu_lvl,
    input  logic [NCPU-1:0]   ipi_sum,
    input  logic [NCPU-1:0]   msg_sum,
    output logic [NCPU-1:0]   irq_out
);

    acc_e                       kind;
    logic [IDX_W-1:0]           ridx;
    logic [NSRC-1:0]            en;
    logic [NCPU-1:0][NSRC-1:0]  msk;
    logic [NSRC-1:0][NCPU-1:0]  route;
    logic [NCPU-1:0][ID_W-1:0]  ack_id;
    logic [31:0]                rd_next;

    mic_decode #(.NSRC(NSRC), .IDX_W(IDX_W)) dec_i (
        .addr (addr),
        .kind (kind),
        .ridx (ridx)
    );

    mic_regs #(.NCPU(NCPU), .NSRC(NSRC), .CPU_W(CPU_W), .IDX_W(IDX_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .kind    (kind),
        .cpu_sel (cpu_sel),
        .wdata   (wdata),
        .ridx    (ridx),
        .en      (en),
        .msk     (msk),
        .route   (route)
    );

    mic_pick #(.NCPU(NCPU), .NSRC(NSRC), .PCPU(PCPU)) pick_i (
        .src_lvl  (src_lvl),
        .pcpu_lvl (pcpu_lvl),
        .ipi_sum  (ipi_sum),
        .msg_sum  (msg_sum),
        .en       (en),
        .msk      (msk),
        .route    (route),
        .ack_id   (ack_id),
        .irq      (irq_out)
    );

    always_comb begin
        rd_next = '0;
        unique case (kind)
            ACC_CTRL:  rd_next[11:2] = 10'(NSRC);
            ACC_ROUTE: rd_next[NCPU-1:0] = route[ridx];
            ACC_CAUSE: begin
                rd_next[0]    = msg_sum[cpu_sel];
                rd_next[PCPU] = pcpu_lvl[cpu_sel];
            end
            ACC_ACK:   rd_next[ID_W-1:0] = ack_id[cpu_sel];
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

endmodule

// File: rtl/mic_top_chk.sv
module mic_top_chk
    import mic_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NSRC  = 32,
    parameter int CPU_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_W-1:0]  cpu_sel,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic [31:0]       rdata,
    input logic [NCPU-1:0]   irq_out
);

    logic rd_ack;
    logic rd_ctrl;
    assign rd_ack  = rd_en && (addr == {1'b1, OFS_ACK});
    assign rd_ctrl = rd_en && (addr == {1'b0, OFS_CTRL});

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (irq_out == '0));

    // R6
    ack_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> (rdata[31:ID_W] == '0));

    // R10
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !irq_out[cpu_sel]) |=> (rdata[ID_W-1:0] == ID_NONE));

    // R10
    busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && irq_out[cpu_sel]) |=> (rdata[ID_W-1:0] < ID_NONE));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R4
    ctrl_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |=> (rdata[11:2] == 10'(NSRC)));

endmodule

bind mic_top mic_top_chk #(.NCPU(NCPU), .NSRC(NSRC), .CPU_W(CPU_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_sel (cpu_sel),
    .addr    (addr),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .irq_out (irq_out)
);

// File: tb/mic_top_tb_top.sv
module mic_top_tb_top;

    localparam int CLK_P = 10;
    localparam int NCPU  = 4;
    localparam int NSRC  = 32;
    localparam int PCPU  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_sel = '0;
    logic [12:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NSRC-1:0] src_lvl = '0;
    logic [NCPU-1:0] pcpu_lvl = '0;
    logic [NCPU-1:0] ipi_sum = '0;
    logic [NCPU-1:0] msg_sum = '0;
    logic [NCPU-1:0] irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    bit       m_en  [NSRC];
    bit       m_msk [NCPU][NSRC];
    bit [3:0] m_rt  [NSRC];

    always #(CLK_P/2) clk = ~clk;

    mic_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .src_lvl(src_lvl), .pcpu_lvl(pcpu_lvl), .ipi_sum(ipi_sum),
        .msg_sum(msg_sum), .irq_out(irq_out)
    );

    function automatic int model_ack(input int c);
        for (int id = 0; id < NSRC; id++) begin
            bit p;
            if (id == 0)         p = ipi_sum[c];
            else if (id == 1)    p = msg_sum[c];
            else if (id == PCPU) p = pcpu_lvl[c];
            else                 p = src_lvl[id] && m_en[id] && m_rt[id][c];
            if (p && !m_msk[c][id]) return id;
        end
        return 1023;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // R10: compare every CPU's request line with the model each cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCPU; c++) begin
                chk("R10 irq_out", int'(irq_out[c]), int'(model_ack(c) != 1023));
            end
        end
    end

    task automatic wr(input bit pc, input [11:0] ofs, input int c, input int d);
        @(posedge clk); #1;
        addr = {pc, ofs}; cpu_sel = 2'(c); wdata = d; wr_en = 1'b1;
        @(posedge clk);
        if (d >= 0 && d < NSRC) begin
            if (!pc && ofs == 12'h030) m_en[d] = 1'b1;
            if (!pc && ofs == 12'h034) m_en[d] = 1'b0;
            if (pc && ofs == 12'h048)  m_msk[c][d] = 1'b1;
            if (pc && ofs == 12'h04C)  m_msk[c][d] = 1'b0;
        end
        if (!pc && ofs >= 12'h100 && ofs < 12'h100 + 12'(4*NSRC))
            m_rt[(ofs - 12'h100) >> 2] = 4'(d);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input bit pc, input [11:0] ofs, input int c, output int d);
        @(posedge clk); #1;
        addr = {pc, ofs}; cpu_sel = 2'(c); rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
        d = int'(rdata);
    endtask

    task automatic ack(input string tag, input int c, input int exp);
        int v;
        rd(1'b1, 12'h044, c, v);
        chk(tag, v, exp);
        chk({tag, " model"}, v, model_ack(c));
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int v;
        for (int s = 0; s < NSRC; s++) begin
            m_en[s] = 1'b0;
            m_rt[s] = 4'd1;
            for (int c = 0; c < NCPU; c++) m_msk[c][s] = 1'b1;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq_out after reset", int'(irq_out), 0);
        rd(1'b0, 12'h10C, 0, v); chk("R1 route 3 reset", v, 1);
        for (int c = 0; c < NCPU; c++) ack("R1 ack reset", c, 1023);
        // R4
        rd(1'b0, 12'h000, 0, v); chk("R4 control word", v, NSRC << 2);

        // R2 / R3 / R5 stage by stage
        src_lvl[7] = 1'b1;
        wr(1'b0, 12'h030, 0, 7);
        ack("R3 still masked", 0, 1023);
        wr(1'b1, 12'h04C, 0, 7);
        ack("R2 enabled and unmasked", 0, 7);
        ack("R3 other cpu masked", 1, 1023);
        wr(1'b1, 12'h04C, 1, 7);
        ack("R5 not routed to cpu1", 1, 1023);
        wr(1'b0, 12'h11C, 0, 2);
        rd(1'b0, 12'h11C, 0, v); chk("R5 route readback", v, 2);
        ack("R5 routed to cpu1", 1, 7);
        ack("R5 unrouted cpu0", 0, 1023);

        // R6 read does not clear; level drop clears
        ack("R6 repeat read", 1, 7);
        src_lvl[7] = 1'b0;
        ack("R6 line dropped", 1, 1023);
        src_lvl[7] = 1'b1;

        // R6 lowest wins
        src_lvl[3] = 1'b1;
        wr(1'b0, 12'h030, 0, 3);
        wr(1'b0, 12'h10C, 0, 2);
        wr(1'b1, 12'h04C, 1, 3);
        ack("R6 lowest id wins", 1, 3);

        // R2 disable and out-of-range alias
        wr(1'b0, 12'h034, 0, 3);
        ack("R2 disabled", 1, 7);
        wr(1'b0, 12'h034, 0, 39);
        ack("R2 out of range ignored", 1, 7);

        // R7 doorbell summaries
        ipi_sum[2] = 1'b1;
        ack("R7 ipi masked", 2, 1023);
        wr(1'b1, 12'h04C, 2, 0);
        ack("R7 ipi id", 2, 0);
        msg_sum[2] = 1'b1;
        wr(1'b1, 12'h04C, 2, 1);
        ack("R7 ipi beats msg", 2, 0);
        wr(1'b1, 12'h048, 2, 0);
        ack("R7 msg id", 2, 1);

        // R8 per-CPU source
        pcpu_lvl[3] = 1'b1;
        wr(1'b1, 12'h04C, 3, PCPU);
        ack("R8 per-cpu without enable", 3, PCPU);
        src_lvl[PCPU] = 1'b1;
        wr(1'b0, 12'h030, 0, PCPU);
        wr(1'b1, 12'h04C, 0, PCPU);
        ack("R8 shared line ignored", 0, 1023);

        // R9 cause bitmap
        msg_sum[3] = 1'b1;
        rd(1'b1, 12'h010, 3, v); chk("R9 cause cpu3", v, 32'h21);
        rd(1'b1, 12'h010, 0, v); chk("R9 cause cpu0", v, 0);

        // R3 remask
        wr(1'b1, 12'h048, 3, PCPU);
        ack("R3 remasked", 3, 1023);

        // R11 hold
        @(posedge clk); #1;
        v = int'(rdata);
        repeat (3) @(posedge clk);
        #1 chk("R11 rdata held", int'(rdata), v);

        repeat (2) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule